// File: doc/BRIEF.md
# Service-Sequence Watchdog Timer

This block guards against runaway software. It counts ticks from one of four clock-enable inputs and raises a reset request when software fails to service it within the selected timeout. Software services it by writing the byte 0x55 and then the byte 0xAA to an 8-bit write-only service port. A completed pair clears the count. A wrong byte, or a write made too early when windowed servicing is selected, raises the reset request at once. Once raised, the request stays high until the system reset clears the block.

The timeout comes from a range bit and a 2-bit code. Code 00 turns the watchdog off. In each range the other three codes give three power-of-two lengths. Two further configuration bits set whether counting continues while the system is in stop mode or in debug mode. When counting is not allowed, the watchdog is off and its count is zero.

The control logic is a four-state machine. OFF is entered from reset and whenever the watchdog is not enabled. OFF moves to ARMED on the first enabled cycle. ARMED moves to KEYED on an accepted 0x55. KEYED moves back to ARMED on an accepted 0xAA, which clears the count. Every other service write made while enabled moves to FAULT. So does a timeout, and so does a write outside the window in windowed mode. FAULT is left only by reset. Any state other than FAULT goes to OFF when the watchdog is disabled. From any state other than FAULT, an enabled timeout goes to FAULT.

Top module: `svc_watchdog`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0, the count is 0 and the state machine is in OFF.
- R2: With `cfg_tmo` = 00 the watchdog is off. The count stays at 0, service writes of any value are ignored, and `rst_req` stays 0.
- R3: With `cfg_long` = 0, the codes 01, 10 and 11 give limits of 2^5, 2^8 and 2^10 ticks. `rst_req` rises at the clock edge that samples the limit-th selected tick counted since the count was last cleared.
- R4: With `cfg_long` = 1, the same codes give limits of 2^13, 2^16 and 2^18 ticks. These lengths are set by parameters. Timing follows the rule of R3.
- R5: Servicing is a write of 0x55 in ARMED followed by a write of 0xAA in KEYED. The edge that accepts the 0xAA clears the count. The next timeout then falls a full limit of ticks after that edge.
- R6: While enabled, a write other than 0x55 in ARMED, or other than 0xAA in KEYED, sets `rst_req` at the next clock edge.
- R7: With `cfg_window` = 1, a service write is accepted only while the count is at least limit minus limit/4. An earlier write sets `rst_req` at the next clock edge.
- R8: While `in_stop` = 1 and `cfg_stop_run` = 0, the watchdog is off and the count is cleared. With `cfg_stop_run` = 1, stop mode has no effect.
- R9: While `in_debug` = 1 and `cfg_dbg_run` = 0, the watchdog is off and the count is cleared. With `cfg_dbg_run` = 1, debug mode has no effect.
- R10: `cfg_src` selects the bit of `tick_in` that is counted: 00 the low-power 1 kHz tick, 01 the internal reference tick, 10 the external oscillator tick, 11 the bus tick. The other bits of `tick_in` have no effect.
- R11: Once `rst_req` is 1 it stays 1 through any configuration change, mode input or service write, until `rst_n` is asserted.
- R12: If a timeout and an otherwise valid completing 0xAA write fall on the same edge, the timeout wins and `rst_req` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_window | input | 1 | 1 selects windowed servicing |
| cfg_long | input | 1 | 0 selects the short range, 1 the long range |
| cfg_tmo | input | 2 | Timeout code; 00 turns the watchdog off |
| cfg_stop_run | input | 1 | 1 keeps counting in stop mode |
| cfg_dbg_run | input | 1 | 1 keeps counting in debug mode |
| cfg_src | input | 2 | Tick source select |
| svc_wr | input | 1 | Service write strobe, one cycle per write |
| svc_data | input | 8 | Service write byte |
| in_stop | input | 1 | System is in stop mode |
| in_debug | input | 1 | System is in debug mode |
| tick_in | input | 4 | Clock-enable ticks, one per source |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench keeps the short-range exponents at their defaults of 5, 8 and 10. It builds the long-range exponents as 11, 12 and 13, so every one of the six lengths expires within a short run while the long-range decode and the wider count are still exercised. Because the short limits are small, the window edge at three quarters of the limit and the same-edge clash between a timeout and a service write can be reached at exact cycles. Random runs over the full range of settings are compared cycle by cycle against a reference model in the bench.

// File: rtl/svc_watchdog_pkg.sv
package svc_watchdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_KEYED = 2'd2,
        ST_FAULT = 2'd3
    } wd_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wd_tick_mux.sv
module wd_tick_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [N_SRC-1:0] hit;

    // one-hot match per source, then OR-reduce
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ticks[g] && (sel == SEL_W'(g));
    end

    assign tick = |hit;

endmodule

// File: rtl/wd_limit.sv
module wd_limit #(
    parameter int SHORT_EXP1 = 5,
    parameter int SHORT_EXP2 = 8,
    parameter int SHORT_EXP3 = 10,
    parameter int LONG_EXP1  = 13,
    parameter int LONG_EXP2  = 16,
    parameter int LONG_EXP3  = 18,
    parameter int CW         = 19
) (
    input  logic          long_rng,
    input  logic [1:0]    code,
    output logic [CW-1:0] limit,
    output logic [CW-1:0] win_start
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        unique case ({long_rng, code})
            3'b001:  limit = ONE << SHORT_EXP1;
            3'b010:  limit = ONE << SHORT_EXP2;
            3'b011:  limit = ONE << SHORT_EXP3;
            3'b101:  limit = ONE << LONG_EXP1;
            3'b110:  limit = ONE << LONG_EXP2;
            3'b111:  limit = ONE << LONG_EXP3;
            default: limit = '0;
        endcase
    end

    // the window opens at three quarters of the period
    assign win_start = limit - (limit >> 2);

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          clear,
    input  logic          hold,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] win_start,
    output logic          expire,
    output logic          in_window
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc   = cnt_q + ONE;
    assign expire    = en && tick && !hold && (cnt_inc >= limit);
    assign in_window = (cnt_q >= win_start);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || clear) begin
            cnt_q <= '0;
        end else if (tick && !hold) begin
            cnt_q <= cnt_inc;
        end
    end

    // R8 / R9: a disabled cycle leaves the count at zero
    p_clear_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

    // R5: an accepted completing write empties the count
    p_clear_on_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R10: without a selected tick the count does not move
    p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wd_seq_fsm.sv
module wd_seq_fsm
    import svc_watchdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       expire,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       window,
    input  logic       in_window,
    output logic       fault,
    output logic       svc_clear
);

    wd_state_t state_q;
    wd_state_t state_d;
    logic      win_ok;

    assign win_ok = !window || in_window;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_d_check: state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAULT: state_d = ST_FAULT;
            ST_OFF: begin
                if (en && expire)     state_d = ST_FAULT;
                else if (en)          state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en)              state_d = ST_OFF;
                else if (expire)      state_d = ST_FAULT;
                else if (wr) begin
                    if (!win_ok)                 state_d = ST_FAULT;
                    else if (data == KEY_FIRST)  state_d = ST_KEYED;
                    else                         state_d = ST_FAULT;
                end
            end
            ST_KEYED: begin
                if (!en)              state_d = ST_OFF;
                else if (expire)      state_d = ST_FAULT;
                else if (wr) begin
                    if (!win_ok)                 state_d = ST_FAULT;
                    else if (data == KEY_SECOND) state_d = ST_ARMED;
                    else                         state_d = ST_FAULT;
                end
            end
            default: state_d = ST_FAULT;
        endcase
    end

    // outputs
    always_comb begin
        fault     = (state_q == ST_FAULT);
        svc_clear = (state_q == ST_KEYED) && en && !expire && wr
                    && win_ok && (data == KEY_SECOND);
    end

    // R11: the fault state is left only through reset
    p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

    // R6: a wrong first key ends in the fault state
    p_bad_first_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && en && wr && data != KEY_FIRST) |=> fault);

    // R7: an early write in windowed mode ends in the fault state
    p_early_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED || state_q == ST_KEYED) && en && wr
         && window && !in_window) |=> fault);

    // R2: a disabled watchdog not in fault rests in OFF
    p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state_q != ST_FAULT) |=> (state_q == ST_OFF));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_watchdog_pkg::*;
#(
    parameter int SHORT_EXP1 = 5,
    parameter int SHORT_EXP2 = 8,
    parameter int SHORT_EXP3 = 10,
    parameter int LONG_EXP1  = 13,
    parameter int LONG_EXP2  = 16,
    parameter int LONG_EXP3  = 18,
    parameter int N_SRC      = 4,
    localparam int SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_window,
    input  logic             cfg_long,
    input  logic [1:0]       cfg_tmo,
    input  logic             cfg_stop_run,
    input  logic             cfg_dbg_run,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic             svc_wr,
    input  logic [7:0]       svc_data,
    input  logic             in_stop,
    input  logic             in_debug,
    input  logic [N_SRC-1:0] tick_in,
    output logic             rst_req
);

    localparam int MAX_EXP = max_of(max_of(max_of(SHORT_EXP1, SHORT_EXP2),
                                           max_of(SHORT_EXP3, LONG_EXP1)),
                                    max_of(LONG_EXP2, LONG_EXP3));
    localparam int CW = MAX_EXP + 1;

    logic          tick;
    logic          en;
    logic [CW-1:0] limit;
    logic [CW-1:0] win_start;
    logic          expire;
    logic          in_window;
    logic          fault;
    logic          svc_clear;

    assign en = (cfg_tmo != 2'b00)
             && !(in_stop  && !cfg_stop_run)
             && !(in_debug && !cfg_dbg_run);

    wd_tick_mux #(.N_SRC(N_SRC)) u_mux (
        .ticks (tick_in),
        .sel   (cfg_src),
        .tick  (tick)
    );

    wd_limit #(
        .SHORT_EXP1 (SHORT_EXP1), .SHORT_EXP2 (SHORT_EXP2), .SHORT_EXP3 (SHORT_EXP3),
        .LONG_EXP1  (LONG_EXP1),  .LONG_EXP2  (LONG_EXP2),  .LONG_EXP3  (LONG_EXP3),
        .CW         (CW)
    ) u_limit (
        .long_rng  (cfg_long),
        .code      (cfg_tmo),
        .limit     (limit),
        .win_start (win_start)
    );

    wd_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .clear     (svc_clear),
        .hold      (fault),
        .limit     (limit),
        .win_start (win_start),
        .expire    (expire),
        .in_window (in_window)
    );

    wd_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .expire    (expire),
        .wr        (svc_wr),
        .data      (svc_data),
        .window    (cfg_window),
        .in_window (in_window),
        .fault     (fault),
        .svc_clear (svc_clear)
    );

    assign rst_req = fault;

    // R3 / R12: a timeout edge always ends with the request raised
    p_expire_raises_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> rst_req);

    // R11: the request never drops without reset
    p_req_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R2: with the off code nothing can start a fault
    p_off_code_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tmo == 2'b00 && !rst_req) |=> !rst_req);

endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;

    localparam int S1 = 5, S2 = 8, S3 = 10;
    localparam int L1 = 11, L2 = 12, L3 = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_window = 1'b0;
    logic       cfg_long = 1'b0;
    logic [1:0] cfg_tmo = 2'b00;
    logic       cfg_stop_run = 1'b0;
    logic       cfg_dbg_run = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       in_stop = 1'b0;
    logic       in_debug = 1'b0;
    logic [3:0] tick_in = 4'h0;
    logic       rst_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    svc_watchdog #(
        .SHORT_EXP1(S1), .SHORT_EXP2(S2), .SHORT_EXP3(S3),
        .LONG_EXP1(L1),  .LONG_EXP2(L2),  .LONG_EXP3(L3)
    ) u_svc_watchdog (
        .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .cfg_long(cfg_long),
        .cfg_tmo(cfg_tmo), .cfg_stop_run(cfg_stop_run), .cfg_dbg_run(cfg_dbg_run),
        .cfg_src(cfg_src), .svc_wr(svc_wr), .svc_data(svc_data),
        .in_stop(in_stop), .in_debug(in_debug), .tick_in(tick_in), .rst_req(rst_req)
    );

    function automatic int exp_limit(input bit lng, input logic [1:0] code);
        int e;
        case (code)
            2'd1: e = lng ? L1 : S1;
            2'd2: e = lng ? L2 : S2;
            2'd3: e = lng ? L3 : S3;
            default: return 0;
        endcase
        return 1 << e;
    endfunction

    // reference model from the requirements: 0 off, 1 armed, 2 keyed, 3 fault
    int m_cnt = 0;
    int m_st = 0;
    always @(posedge clk) begin
        int lim;
        bit en;
        bit tk;
        if (!rst_n) begin
            m_cnt = 0;
            m_st = 0;
        end else if (m_st != 3) begin
            lim = exp_limit(cfg_long, cfg_tmo);
            en = (cfg_tmo != 0) && !(in_stop && !cfg_stop_run) && !(in_debug && !cfg_dbg_run);
            tk = tick_in[cfg_src];
            if (!en) begin
                m_cnt = 0; m_st = 0;
            end else if (tk && (m_cnt + 1 >= lim)) begin
                m_st = 3;
            end else if (m_st == 0) begin
                m_st = 1; if (tk) m_cnt++;
            end else if (svc_wr) begin
                if (cfg_window && (m_cnt < lim - lim / 4)) m_st = 3;
                else if (m_st == 1) begin
                    if (svc_data == 8'h55) begin m_st = 2; if (tk) m_cnt++; end
                    else m_st = 3;
                end else begin
                    if (svc_data == 8'hAA) begin m_st = 1; m_cnt = 0; end
                    else m_st = 3;
                end
            end else if (tk) begin
                m_cnt++;
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            checks++;
            if (rst_req !== (m_st == 3)) begin
                errors++;
                $display("FAIL %s model: rst_req=%0b expected %0b at %0t",
                         cur_tag, rst_req, (m_st == 3), $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_window = 0; cfg_long = 0; cfg_tmo = 0; cfg_stop_run = 0; cfg_dbg_run = 0;
        cfg_src = 2'd3; svc_wr = 0; svc_data = 0; in_stop = 0; in_debug = 0; tick_in = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // negedges until rst_req is seen, -1 if never within maxc
    task automatic measure(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (rst_req) return;
        end
        n = -1;
    endtask

    task automatic write_byte(input logic [7:0] b);
        svc_wr = 1'b1; svc_data = b;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic service();
        svc_wr = 1'b1; svc_data = 8'h55;
        @(negedge clk);
        svc_data = 8'hAA;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic start(input bit lng, input logic [1:0] code, input bit win);
        do_reset();
        cfg_long = lng; cfg_tmo = code; cfg_window = win; cfg_src = 2'd3; tick_in = 4'hF;
    endtask

    initial begin
        int n;
        logic [7:0] next_key;
        void'($urandom(32'h5eed_0c0d));

        // R1 reset state
        cur_tag = "R1";
        do_reset();
        @(negedge clk);
        check("R1 reset rst_req", rst_req, 0);
        cfg_tmo = 2'd1; tick_in = 4'hF;
        cyc(3);
        check("R1 no early request", rst_req, 0);

        // R2 off code ignores ticks and junk writes
        cur_tag = "R2";
        start(0, 2'd0, 0);
        for (int i = 0; i < 300; i++) begin
            if (i % 7 == 0) write_byte(8'h13); else @(negedge clk);
        end
        check("R2 off code rst_req", rst_req, 0);
        cfg_tmo = 2'd1;
        measure(100, n);
        check("R2 count stayed zero while off", n, 32);

        // R3 short range
        cur_tag = "R3";
        for (int c = 1; c < 4; c++) begin
            start(0, 2'(c), 0);
            measure(5000, n);
            check($sformatf("R3 short code %0d", c), n, exp_limit(0, 2'(c)));
        end

        // R4 long range
        cur_tag = "R4";
        for (int c = 1; c < 4; c++) begin
            start(1, 2'(c), 0);
            measure(20000, n);
            check($sformatf("R4 long code %0d", c), n, exp_limit(1, 2'(c)));
        end

        // R5 regular servicing keeps it quiet, last service restarts the period
        cur_tag = "R5";
        start(0, 2'd1, 0);
        for (int i = 0; i < 10; i++) begin
            cyc(18);
            service();
        end
        check("R5 serviced rst_req", rst_req, 0);
        measure(100, n);
        check("R5 period after service", n, 32);

        // R6 wrong first and wrong second key
        cur_tag = "R6";
        start(0, 2'd3, 0);
        cyc(5);
        write_byte(8'h12);
        check("R6 wrong first key", rst_req, 1);
        start(0, 2'd3, 0);
        cyc(5);
        write_byte(8'h55);
        check("R6 after good first key", rst_req, 0);
        write_byte(8'h5A);
        check("R6 wrong second key", rst_req, 1);

        // R7 windowed mode
        cur_tag = "R7";
        start(0, 2'd1, 1);
        cyc(10);
        write_byte(8'h55);
        check("R7 early write in window mode", rst_req, 1);
        start(0, 2'd1, 1);
        for (int i = 0; i < 5; i++) begin
            cyc(25);
            service();
        end
        check("R7 in-window servicing", rst_req, 0);

        // R8 stop gating
        cur_tag = "R8";
        start(0, 2'd1, 0);
        cyc(20);
        in_stop = 1'b1;
        cyc(3);
        check("R8 no request in stop", rst_req, 0);
        in_stop = 1'b0;
        measure(100, n);
        check("R8 count cleared by stop", n, 32);
        start(0, 2'd1, 0);
        cfg_stop_run = 1'b1; in_stop = 1'b1;
        measure(100, n);
        check("R8 counting in stop", n, 32);

        // R9 debug gating
        cur_tag = "R9";
        start(0, 2'd1, 0);
        cyc(20);
        in_debug = 1'b1;
        cyc(3);
        check("R9 no request in debug", rst_req, 0);
        in_debug = 1'b0;
        measure(100, n);
        check("R9 count cleared by debug", n, 32);
        start(0, 2'd1, 0);
        cfg_dbg_run = 1'b1; in_debug = 1'b1;
        measure(100, n);
        check("R9 counting in debug", n, 32);

        // R10 tick source select
        cur_tag = "R10";
        for (int s = 0; s < 4; s++) begin
            start(0, 2'd1, 0);
            cfg_src = 2'(s);
            tick_in = ~(4'b0001 << s);
            cyc(100);
            check($sformatf("R10 unselected ticks src %0d", s), rst_req, 0);
            tick_in = 4'b0001 << s;
            measure(100, n);
            check($sformatf("R10 selected tick src %0d", s), n, 32);
        end

        // R11 sticky request
        cur_tag = "R11";
        start(0, 2'd1, 0);
        measure(100, n);
        cfg_tmo = 2'd0; in_stop = 1'b1;
        service();
        cyc(20);
        check("R11 request held", rst_req, 1);
        do_reset();
        @(negedge clk);
        check("R11 cleared by reset", rst_req, 0);

        // R12 timeout beats a completing write on the same edge
        cur_tag = "R12";
        start(0, 2'd1, 0);
        cyc(10);
        write_byte(8'h55);
        cyc(20);
        svc_wr = 1'b1; svc_data = 8'hAA;
        @(negedge clk);
        svc_wr = 1'b0;
        check("R12 timeout wins", rst_req, 1);

        // random runs against the model
        for (int ep = 0; ep < 16; ep++) begin
            cur_tag = "R5/R6/R7 random";
            do_reset();
            cfg_long = ($urandom % 4) == 0;
            cfg_tmo = 2'($urandom);
            cfg_window = 1'($urandom);
            cfg_stop_run = 1'($urandom);
            cfg_dbg_run = 1'($urandom);
            cfg_src = 2'($urandom);
            next_key = 8'h55;
            for (int i = 0; i < 2500; i++) begin
                @(negedge clk);
                tick_in = 4'($urandom);
                if ($urandom % 80 == 0) in_stop = ~in_stop;
                if ($urandom % 80 == 0) in_debug = ~in_debug;
                svc_wr = ($urandom % 12) == 0;
                if (svc_wr) begin
                    if ($urandom % 25 == 0) svc_data = 8'($urandom);
                    else begin
                        svc_data = next_key;
                        next_key = (next_key == 8'h55) ? 8'hAA : 8'h55;
                    end
                end
            end
            svc_wr = 1'b0;
        end

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule